// File: doc/BRIEF.md
# Saturating Signed Arithmetic Unit with Status Flags

This block performs 32-bit signed arithmetic that saturates instead of wrapping. It can add two register operands, add a small signed immediate to a register, subtract one register from another in either direction, or subtract a 16-bit signed immediate from a register. The caller presents a source operand, a destination operand, an immediate field and an operation code together with a valid strobe. One cycle later the block presents the result, meant for the destination, along with a registered status word.

The status word holds zero, sign, carry/borrow and overflow flags. All four are derived from the raw wrapped 32-bit result, before any clamping. It also holds a sticky saturation flag. Arithmetic can set the saturation flag but never clears it. Only a dedicated synchronous clear input or reset clears it. When a result overflows, the output is pinned to the most negative or most positive 32-bit value, and the flags still describe the wrapped value.

Top module: `sat_alu`

## Requirements
- R1: After reset, `result` is 0, `out_valid` is 0 and all five flags are 0.
- R2: Op code 0 computes `dst_b + src_a`. Op code 1 computes `dst_b + sext(imm[4:0])`, where the 5-bit field is sign-extended to 32 bits.
- R3: Op code 2 computes `dst_b - src_a`. Op code 3 computes `src_a - dst_b`. Op code 4 computes `dst_b - sext(imm[15:0])`. Every result is intended for the destination.
- R4: For an accepted op, `result` and the flags appear on the first rising edge after the strobe, and `out_valid` is high for exactly that one cycle.
- R5: When signed overflow occurs, `result` is clamped. It becomes 0x80000000 if the first addend (source or immediate) or the minuend is negative, and 0x7FFFFFFF otherwise.
- R6: `flag_z` and `flag_s` describe the raw wrapped result, even when `result` is clamped.
- R7: For adds, `flag_cy` is the unsigned carry out of bit 31. For subtracts, `flag_cy` is set when the minuend, taken as unsigned, is less than the subtrahend.
- R8: For an add, `flag_ov` is set when both operands share a sign and the raw result has the other sign. For a subtract, `flag_ov` is set when the operand signs differ and the raw result's sign differs from the minuend's sign.
- R9: `flag_sat` is set by any accepted op that overflows, and stays set across later ops. It is cleared only by `sat_clr` (synchronously) or by reset. If `sat_clr` and an overflowing op arrive in the same cycle, `flag_sat` ends at 1.
- R10: When no op is accepted, `result`, `flag_z`, `flag_s`, `flag_cy` and `flag_ov` hold their values. This covers cycles where `in_valid` is low and cycles carrying reserved op codes 5 to 7. A reserved op also raises no `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| in_valid | input | 1 | Operation strobe |
| op | input | 3 | Operation code (0 to 4 legal) |
| src_a | input | 32 | Source operand |
| dst_b | input | 32 | Destination operand |
| imm | input | 16 | Immediate field |
| sat_clr | input | 1 | Synchronous clear of the sticky saturation flag |
| out_valid | output | 1 | Result valid, one cycle after an accepted op |
| result | output | 32 | Saturated result |
| flag_z | output | 1 | Raw result is zero |
| flag_s | output | 1 | Raw result bit 31 |
| flag_cy | output | 1 | Carry (add) or borrow (subtract) |
| flag_ov | output | 1 | Signed overflow |
| flag_sat | output | 1 | Sticky saturation |

## Verification
The bench pushes operations through every code and checks four kinds of corner case. The first is overflow at both extremes in each form. A design that clamped by the wrong operand's sign would return the opposite extreme. The second is 0x80000000 + 0x80000000, whose raw sum is zero. A design that took its flags from the clamped value would miss `flag_z` there and report the wrong sign. The third is reverse subtraction with a negative subtrahend and small values that borrow. A design that mixed up minuend and subtrahend would show the wrong overflow or borrow. The last covers sticky-flag clears, including a clear that coincides with an overflowing op, plus idle and reserved-op cycles. A leaky register would there drop the saturation flag or alter the held result.

// File: rtl/sat_alu.sv
module sat_alu #(
  parameter int W     = 32,
  parameter int IMM_S = 5,
  parameter int IMM_L = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [2:0]       op,
  input  logic [W-1:0]     src_a,
  input  logic [W-1:0]     dst_b,
  input  logic [IMM_L-1:0] imm,
  input  logic             sat_clr,
  output logic             out_valid,
  output logic [W-1:0]     result,
  output logic             flag_z,
  output logic             flag_s,
  output logic             flag_cy,
  output logic             flag_ov,
  output logic             flag_sat
);
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] x, y, raw, clamped;
  logic [W:0]   wide;
  logic         is_sub, legal, fire, ov;

  wire [W-1:0] imm_s = {{(W-IMM_S){imm[IMM_S-1]}}, imm[IMM_S-1:0]};
  wire [W-1:0] imm_l = {{(W-IMM_L){imm[IMM_L-1]}}, imm};

  // x is the first addend or the minuend; its sign picks the clamp direction
  always_comb begin
    is_sub = 1'b0;
    legal  = 1'b1;
    x      = src_a;
    y      = dst_b;
    case (op)
      3'd0: begin x = src_a; y = dst_b; end
      3'd1: begin x = imm_s; y = dst_b; end
      3'd2: begin x = dst_b; y = src_a; is_sub = 1'b1; end
      3'd3: begin x = src_a; y = dst_b; is_sub = 1'b1; end
      3'd4: begin x = dst_b; y = imm_l; is_sub = 1'b1; end
      default: legal = 1'b0;
    endcase
  end

  assign wide    = is_sub ? ({1'b0, x} - {1'b0, y}) : ({1'b0, x} + {1'b0, y});
  assign raw     = wide[W-1:0];
  assign ov      = (is_sub ? (x[W-1] != y[W-1]) : (x[W-1] == y[W-1])) && (raw[W-1] != x[W-1]);
  assign clamped = ov ? (x[W-1] ? MAX_NEG : MAX_POS) : raw;
  assign fire    = in_valid && legal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_z    <= 1'b0;
      flag_s    <= 1'b0;
      flag_cy   <= 1'b0;
      flag_ov   <= 1'b0;
      flag_sat  <= 1'b0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        result  <= clamped;
        flag_z  <= (raw == '0);
        flag_s  <= raw[W-1];
        flag_cy <= wide[W];
        flag_ov <= ov;
      end
      flag_sat <= (flag_sat && !sat_clr) || (fire && ov);
    end
  end

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_sat && !sat_clr |=> flag_sat);
  p_ov_sets_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flag_ov |-> flag_sat);
  p_clamp_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flag_ov |-> (result == MAX_POS || result == MAX_NEG));
  p_zero_raw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flag_z && !flag_ov |-> result == '0);
  p_sign_raw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !flag_ov |-> flag_s == result[W-1]);
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable({result, flag_z, flag_s, flag_cy, flag_ov}));
  p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op > 3'd4 |=> !out_valid);
endmodule

// File: tb/test_sat_alu.sv
module test_sat_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] src_a = '0, dst_b = '0;
  logic [15:0] imm = '0;
  logic        sat_clr = 1'b0;
  logic        out_valid, flag_z, flag_s, flag_cy, flag_ov, flag_sat;
  logic [31:0] result;

  sat_alu i_sat_alu (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .src_a(src_a), .dst_b(dst_b), .imm(imm), .sat_clr(sat_clr),
    .out_valid(out_valid), .result(result), .flag_z(flag_z), .flag_s(flag_s),
    .flag_cy(flag_cy), .flag_ov(flag_ov), .flag_sat(flag_sat));

  always #2.5 clk = ~clk;

  typedef struct {
    logic [31:0] res;
    logic z, s, cy, ov, sat;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t last;
  int checks = 0, fails = 0;
  logic exp_sat = 1'b0;
  logic monitor_on = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [2:0] o, input logic [31:0] a,
      input logic [31:0] b, input logic [15:0] im, input string tag);
    exp_t e;
    longint m, s, r;
    longint unsigned um, us;
    logic sub;
    sub = (o >= 3'd2);
    case (o)
      3'd0: begin m = longint'($signed(a)); s = longint'($signed(b)); end
      3'd1: begin m = longint'($signed(im[4:0])); s = longint'($signed(b)); end
      3'd2: begin m = longint'($signed(b)); s = longint'($signed(a)); end
      3'd3: begin m = longint'($signed(a)); s = longint'($signed(b)); end
      default: begin m = longint'($signed(b)); s = longint'($signed(im)); end
    endcase
    um = longint'(m) & 64'hFFFF_FFFF;
    us = longint'(s) & 64'hFFFF_FFFF;
    r = sub ? m - s : m + s;
    e.res = r[31:0];
    e.z = (r[31:0] == 32'd0);
    e.s = r[31];
    e.cy = sub ? (um < us) : ((um + us) > 64'hFFFF_FFFF);
    e.ov = (r > 64'sd2147483647) || (r < -64'sd2147483648);
    if (r > 64'sd2147483647) e.res = 32'h7FFF_FFFF;
    if (r < -64'sd2147483648) e.res = 32'h8000_0000;
    e.tag = tag;
    return e;
  endfunction

  task automatic do_op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
      input logic [15:0] im, input logic clr, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; op = o; src_a = a; dst_b = b; imm = im; sat_clr = clr;
    e = model(o, a, b, im, tag);
    exp_sat = (exp_sat && !clr) || e.ov;
    e.sat = exp_sat;
    q.push_back(e);
    last = e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; sat_clr = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (monitor_on && out_valid) begin
      if (q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R4 unexpected out_valid actual=1 expected=0");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, result, e.res, "result");
        chk(e.tag, {31'd0, flag_z}, {31'd0, e.z}, "flag_z");
        chk(e.tag, {31'd0, flag_s}, {31'd0, e.s}, "flag_s");
        chk(e.tag, {31'd0, flag_cy}, {31'd0, e.cy}, "flag_cy");
        chk(e.tag, {31'd0, flag_ov}, {31'd0, e.ov}, "flag_ov");
        chk(e.tag, {31'd0, flag_sat}, {31'd0, e.sat}, "flag_sat");
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", result, 32'd0, "result");
    chk("R1", {27'd0, out_valid, flag_z, flag_s, flag_cy, flag_ov}, 32'd0, "valid/flags");
    chk("R1", {31'd0, flag_sat}, 32'd0, "flag_sat");
    rst_n = 1'b1;
    monitor_on = 1'b1;

    do_op(3'd0, 32'd5, 32'd7, 16'd0, 1'b0, "R2");
    do_op(3'd1, 32'd0, 32'd10, 16'h001F, 1'b0, "R2/R7");
    do_op(3'd1, 32'd0, 32'd3, 16'hFFF0, 1'b0, "R2");
    do_op(3'd2, 32'd30, 32'd100, 16'd0, 1'b0, "R3");
    do_op(3'd3, 32'd30, 32'd100, 16'd0, 1'b0, "R3");
    do_op(3'd4, 32'd0, 32'd5, 16'h8000, 1'b0, "R3");
    do_op(3'd2, 32'd2, 32'd1, 16'd0, 1'b0, "R7");
    do_op(3'd0, 32'd1, 32'h7FFF_FFFF, 16'd0, 1'b0, "R5/R8");
    do_op(3'd0, 32'h8000_0000, 32'hFFFF_FFFF, 16'd0, 1'b0, "R5/R7");
    do_op(3'd0, 32'h8000_0000, 32'h8000_0000, 16'd0, 1'b0, "R6");
    do_op(3'd2, 32'd1, 32'h8000_0000, 16'd0, 1'b0, "R5/R8");
    do_op(3'd3, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'd0, 1'b0, "R5/R8");
    do_op(3'd4, 32'd0, 32'h7FFF_FFF0, 16'hFFF0, 1'b0, "R5/R8");
    do_op(3'd3, 32'h8000_0000, 32'd1, 16'd0, 1'b0, "R5/R8");
    do_op(3'd0, 32'd1, 32'd2, 16'd0, 1'b0, "R9");
    idle(2);
    chk("R9", {31'd0, flag_sat}, 32'd1, "sticky after idle");
    chk("R10", result, last.res, "result held while idle");
    chk("R10", {28'd0, flag_z, flag_s, flag_cy, flag_ov}, {28'd0, last.z, last.s, last.cy, last.ov}, "flags held while idle");

    @(negedge clk);
    sat_clr = 1'b1; exp_sat = 1'b0;
    @(negedge clk);
    sat_clr = 1'b0;
    chk("R9", {31'd0, flag_sat}, 32'd0, "cleared by sat_clr");
    do_op(3'd0, 32'd4, 32'd4, 16'd0, 1'b0, "R9");
    do_op(3'd2, 32'd0, 32'd0, 16'd0, 1'b0, "R6/R9");
    do_op(3'd0, 32'h7000_0000, 32'h7000_0000, 16'd0, 1'b1, "R9 clear+overflow");
    do_op(3'd3, 32'd5, 32'd5, 16'd0, 1'b0, "R4");
    idle(1);

    for (int k = 5; k < 8; k++) begin
      @(negedge clk);
      in_valid = 1'b1; op = 3'(k); src_a = 32'h1234_5678; dst_b = 32'h7FFF_FFFF; imm = 16'hFFFF;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R10", {31'd0, out_valid}, 32'd0, "reserved op out_valid");
      chk("R10", result, last.res, "reserved op result");
      chk("R10", {27'd0, flag_z, flag_s, flag_cy, flag_ov, flag_sat},
          {27'd0, last.z, last.s, last.cy, last.ov, last.sat}, "reserved op flags");
    end
    idle(2);
    chk("R4", 32'(q.size()), 32'd0, "scoreboard drained");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule